// File: doc/BRIEF.md
# Device-Memory Burst Splitter

This block sits between a processor's load/store unit and an AXI3 master port. It serves accesses to Device or Strongly Ordered memory. Each request gives a start address, an access kind, a direction and, for multi-word accesses, a register count. The block turns the request into a series of address-phase commands and issues them one at a time over a valid/ready handshake. Every command carries an address, an INCR burst type, a transfer size and a burst length. Each command also carries the byte-lane write strobes for each of its beats. The block moves no data and collects no responses.

For these memory types, accesses narrower than a word keep their own size and never split. Word and multi-word accesses always use 32-bit beats. They are cut into bursts of at most two beats, and a two-beat burst always starts on an 8-byte boundary. An address that is not aligned to the access size gets no commands. It raises an alignment fault instead. A pulse marks the end of each sequence, and the block refuses new requests while a sequence is still in progress.

Top module: `devmem_burst_split`

## Requirements
- R1: While reset is held and right after it, `reqReady` is 1 and `cmdValid`, `done` and `alignFault` are 0.
- R2: A byte request (`reqKind`=0) produces exactly one command with the request address, `cmdSize`=0, `cmdLen`=0 and `cmdBurst`=2'b01. For a write, `beat0Strb` is the one-hot value 1<<addr[1:0] (lanes 0001, 0010, 0100, 1000), and `beat1Strb` is 0000.
- R3: A halfword request (`reqKind`=1) at an even address produces exactly one command with `cmdSize`=1 and `cmdLen`=0. For a write, `beat0Strb` is 0011 when addr[1]=0 and 1100 when addr[1]=1.
- R4: An alignment fault occurs for a halfword request with addr[0]=1, and for a word or multi request with addr[1:0]≠0. On a fault, `alignFault` is 1 for exactly the cycle after the request is accepted. No command is issued, and `reqReady` stays 1.
- R5: A word request (`reqKind`=2) at an aligned address produces one command with `cmdSize`=2 and `cmdLen`=0.
- R6: A multi request (`reqKind`=3, word count `reqCountM1`+1, 1 to 16) produces commands with `cmdSize`=2. Each command has two beats (`cmdLen`=1) when its address has bit 2 clear and at least two words remain, and one beat (`cmdLen`=0) otherwise. The next command's address is the current one plus 4 per beat. For example, five words from offset 0 give bursts of 2, 2 and 1 beats at +0, +8 and +0x10. Five words from offset 4 give 1, 2 and 2 beats at +4, +8 and +0x10.
- R7: Every word beat of a word or multi write has strobe 1111. An unused second beat has strobe 0000. Every strobe is 0000 for a read. `cmdWrite` equals the request's write flag.
- R8: While `cmdValid`=1 and `cmdReady`=0, the command outputs hold still. The sequence advances only on a command handshake.
- R9: `done` is 1 for exactly the cycle after the final command handshake. In that cycle `cmdValid` is 0.
- R10: `reqReady` is 0 from the cycle after a request is accepted until `done` rises. Requests presented during that time are ignored and do not change the commands that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request presented |
| reqReady | output | 1 | Block idle and able to take a request |
| reqAddr | input | ADDR_W | Start byte address |
| reqKind | input | 2 | 0 byte, 1 halfword, 2 word, 3 multi-word |
| reqCountM1 | input | CNT_W | Word count minus one for multi requests |
| reqWrite | input | 1 | 1 write, 0 read |
| cmdValid | output | 1 | Command on the outputs is valid |
| cmdReady | input | 1 | Downstream takes the command |
| cmdAddr | output | ADDR_W | Burst start address |
| cmdBurst | output | 2 | Burst type, always INCR (01) |
| cmdSize | output | 3 | Transfer size code (0 byte, 1 halfword, 2 word) |
| cmdLen | output | 4 | Burst length minus one |
| cmdWrite | output | 1 | Direction of the command |
| beat0Strb | output | 4 | Byte strobes of the first beat |
| beat1Strb | output | 4 | Byte strobes of the second beat |
| alignFault | output | 1 | One-cycle pulse for a misaligned request |
| done | output | 1 | One-cycle pulse after the last command |

## Verification
Two events can land in the same cycle. The first is the `done` pulse of one sequence. The second is the acceptance of the next request, or a fault on it, because the block is already idle while `done` is high. The bench presents every new request in the very cycle it checks `done`, so each back-to-back case is judged on both the finished sequence and the new one. It also holds `cmdReady` low at random and keeps presenting junk requests while a sequence is busy. The bench then checks that the command fields stay stable and that the junk requests leave no trace in the commands that follow.

// File: rtl/devmem_split_pkg.sv
package devmem_split_pkg;

  localparam int LANE_BYTES = 4;
  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef enum logic [1:0] {
    KIND_BYTE  = 2'd0,
    KIND_HALF  = 2'd1,
    KIND_WORD  = 2'd2,
    KIND_MULTI = 2'd3
  } accKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new request
    logic advance;  // current command handshaken
    logic active;   // a sequence is in progress
  } ctrlStrb_t;

  function automatic logic isMisaligned(accKind_e kind, logic [1:0] lowAddr);
    case (kind)
      KIND_BYTE: isMisaligned = 1'b0;
      KIND_HALF: isMisaligned = lowAddr[0];
      default:   isMisaligned = (lowAddr != 2'b00);
    endcase
  endfunction

endpackage

// File: rtl/devmem_split_dp.sv
module devmem_split_dp
  import devmem_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrb_t                    ctrl,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [1:0]                   reqKind,
  input  logic [CNT_W-1:0]             reqCountM1,
  input  logic                         reqWrite,
  output logic                         reqBad,
  output logic                         lastCmd,
  output logic [ADDR_W-1:0]            cmdAddr,
  output logic [2:0]                   cmdSize,
  output logic [3:0]                   cmdLen,
  output logic                         cmdWrite,
  output logic [LANE_BYTES-1:0]        beat0Strb,
  output logic [LANE_BYTES-1:0]        beat1Strb
);

  localparam int REM_W = CNT_W + 1;

  logic [ADDR_W-1:0] curAddr;
  logic [REM_W-1:0]  remWords;
  accKind_e          curKind;
  logic              curWrite;
  logic              twoBeat;
  logic [REM_W-1:0]  beatsNow;
  logic [LANE_BYTES-1:0] laneSel;

  assign reqBad = isMisaligned(accKind_e'(reqKind), reqAddr[1:0]);

  // a pair of beats only from an 8-byte aligned address with two words left
  assign twoBeat  = !curAddr[2] && (remWords >= REM_W'(2));
  assign beatsNow = twoBeat ? REM_W'(2) : REM_W'(1);
  assign lastCmd  = (remWords == beatsNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remWords <= '0;
      curKind  <= KIND_BYTE;
      curWrite <= 1'b0;
    end else if (ctrl.load) begin
      curAddr  <= reqAddr;
      curKind  <= accKind_e'(reqKind);
      curWrite <= reqWrite;
      remWords <= (accKind_e'(reqKind) == KIND_MULTI)
                  ? REM_W'(reqCountM1) + REM_W'(1) : REM_W'(1);
    end else if (ctrl.advance) begin
      curAddr  <= curAddr + (twoBeat ? ADDR_W'(8) : ADDR_W'(4));
      remWords <= remWords - beatsNow;
    end
  end

  always_comb begin
    case (curKind)
      KIND_BYTE: cmdSize = 3'd0;
      KIND_HALF: cmdSize = 3'd1;
      default:   cmdSize = 3'd2;
    endcase
  end

  assign cmdAddr  = curAddr;
  assign cmdLen   = {3'b000, twoBeat};
  assign cmdWrite = curWrite;

  for (genvar ln = 0; ln < LANE_BYTES; ln++) begin : g_lane
    localparam logic [1:0] LIDX = 2'(ln);
    assign laneSel[ln] = (curKind == KIND_BYTE) ? (curAddr[1:0] == LIDX) :
                         (curKind == KIND_HALF) ? (curAddr[1] == LIDX[1]) : 1'b1;
    assign beat0Strb[ln] = curWrite & laneSel[ln];
    assign beat1Strb[ln] = curWrite & twoBeat;
  end

  AST_SUBWORD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active && (cmdSize != 3'd2) |-> (cmdLen == 4'd0)); // R2
  AST_PAIR_ON_8B: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active && (cmdLen == 4'd1) |-> (cmdAddr[2:0] == 3'b000)); // R6
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active && (cmdSize == 3'd2) |-> (cmdAddr[1:0] == 2'b00)); // R4
  AST_REMAIN_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active |-> (remWords != '0)); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active && !ctrl.advance && !ctrl.load |=> $stable(cmdAddr) && $stable(cmdLen)); // R8

endmodule

// File: rtl/devmem_split_ctrl.sv
module devmem_split_ctrl
  import devmem_split_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqBad,
  input  logic      cmdReady,
  input  logic      lastCmd,
  output logic      reqReady,
  output logic      cmdValid,
  output logic      done,
  output logic      alignFault,
  output ctrlStrb_t strb
);

  typedef enum logic {ST_IDLE, ST_BUSY} state_e;

  state_e state;
  logic   accept;

  assign reqReady = (state == ST_IDLE);
  assign cmdValid = (state == ST_BUSY);
  assign accept   = reqValid && reqReady;

  assign strb.load    = accept && !reqBad;
  assign strb.advance = cmdValid && cmdReady;
  assign strb.active  = cmdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      alignFault <= 1'b0;
    end else begin
      done       <= 1'b0;
      alignFault <= accept && reqBad;
      case (state)
        ST_IDLE: if (strb.load) state <= ST_BUSY;
        ST_BUSY: if (strb.advance && lastCmd) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !reqReady); // R10
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid); // R8
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !cmdValid && !done); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cmdValid); // R9

endmodule

// File: rtl/devmem_burst_split.sv
module devmem_burst_split
  import devmem_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic [CNT_W-1:0]  reqCountM1,
  input  logic              reqWrite,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [1:0]        cmdBurst,
  output logic [2:0]        cmdSize,
  output logic [3:0]        cmdLen,
  output logic              cmdWrite,
  output logic [3:0]        beat0Strb,
  output logic [3:0]        beat1Strb,
  output logic              alignFault,
  output logic              done
);

  ctrlStrb_t strb;
  logic      reqBad;
  logic      lastCmd;

  assign cmdBurst = BURST_INCR;

  devmem_split_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqBad     (reqBad),
    .cmdReady   (cmdReady),
    .lastCmd    (lastCmd),
    .reqReady   (reqReady),
    .cmdValid   (cmdValid),
    .done       (done),
    .alignFault (alignFault),
    .strb       (strb)
  );

  devmem_split_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (strb),
    .reqAddr    (reqAddr),
    .reqKind    (reqKind),
    .reqCountM1 (reqCountM1),
    .reqWrite   (reqWrite),
    .reqBad     (reqBad),
    .lastCmd    (lastCmd),
    .cmdAddr    (cmdAddr),
    .cmdSize    (cmdSize),
    .cmdLen     (cmdLen),
    .cmdWrite   (cmdWrite),
    .beat0Strb  (beat0Strb),
    .beat1Strb  (beat1Strb)
  );

endmodule

// File: tb/tb_devmem_burst_split.sv
module tb_devmem_burst_split;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN, reqValid, reqReady, reqWrite, cmdValid, cmdReady;
  logic [ADDR_W-1:0] reqAddr, cmdAddr;
  logic [1:0]        reqKind, cmdBurst;
  logic [CNT_W-1:0]  reqCountM1;
  logic [2:0]        cmdSize;
  logic [3:0]        cmdLen, beat0Strb, beat1Strb;
  logic              cmdWrite, alignFault, done;

  devmem_burst_split #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqKind(reqKind), .reqCountM1(reqCountM1),
    .reqWrite(reqWrite), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdBurst(cmdBurst), .cmdSize(cmdSize),
    .cmdLen(cmdLen), .cmdWrite(cmdWrite), .beat0Strb(beat0Strb),
    .beat1Strb(beat1Strb), .alignFault(alignFault), .done(done)
  );

  int nChk = 0;
  int nBad = 0;

  logic [31:0] eAddr [0:15];
  logic [3:0]  eLen  [0:15];
  logic [2:0]  eSize [0:15];
  logic [3:0]  eS0   [0:15];
  logic [3:0]  eS1   [0:15];
  int          eN;
  logic        eFault;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected command list from the requirements
  task automatic plan(input logic [31:0] addr, input logic [1:0] kind,
                      input logic [3:0] cntM1, input logic wr);
    eN = 0;
    eFault = (kind == 2'd1 && addr[0]) || (kind >= 2'd2 && addr[1:0] != 2'b00);
    if (eFault) return;
    if (kind < 2'd2) begin
      eAddr[0] = addr; eLen[0] = 4'd0; eSize[0] = {1'b0, kind};
      if (kind == 2'd0) eS0[0] = wr ? (4'b0001 << addr[1:0]) : 4'b0000;
      else              eS0[0] = wr ? (addr[1] ? 4'b1100 : 4'b0011) : 4'b0000;
      eS1[0] = 4'b0000;
      eN = 1;
    end else begin
      int rem = (kind == 2'd2) ? 1 : int'(cntM1) + 1;
      logic [31:0] a = addr;
      while (rem > 0) begin
        logic two = !a[2] && rem >= 2;
        eAddr[eN] = a; eLen[eN] = two ? 4'd1 : 4'd0; eSize[eN] = 3'd2;
        eS0[eN] = wr ? 4'b1111 : 4'b0000;
        eS1[eN] = (wr && two) ? 4'b1111 : 4'b0000;
        eN++;
        a = a + (two ? 32'd8 : 32'd4);
        rem = rem - (two ? 2 : 1);
      end
    end
  endtask

  // called at a negedge; returns at the negedge where done/fault is checked
  task automatic runReq(input logic [31:0] addr, input logic [1:0] kind,
                        input logic [3:0] cntM1, input logic wr, input int stallPct);
    string tg;
    string sg;
    logic stall;
    tg = (kind == 2'd0) ? "R2" : (kind == 2'd1) ? "R3" : (kind == 2'd2) ? "R5" : "R6";
    sg = (kind < 2'd2) ? tg : "R7";
    plan(addr, kind, cntM1, wr);
    chk("R10 ready before request", reqReady, 1);
    reqValid = 1'b1; reqAddr = addr; reqKind = kind; reqCountM1 = cntM1; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    if (eFault) begin
      chk("R4 fault pulse, no command, ready", {alignFault, cmdValid, reqReady}, 3'b101);
      return;
    end
    chk("R4 no fault on aligned request", alignFault, 0);
    chk("R9 done low while busy", done, 0);
    for (int i = 0; i < eN; i++) begin
      do begin
        stall = ($urandom % 100) < stallPct;
        chk({tg, " command fields"}, {cmdValid, cmdAddr, cmdLen, cmdSize, cmdBurst},
            {1'b1, eAddr[i], eLen[i], eSize[i], 2'b01});
        chk({sg, " strobes"}, {beat0Strb, beat1Strb}, {eS0[i], eS1[i]});
        chk("R7 direction", cmdWrite, wr);
        chk("R10 busy refuses", reqReady, 0);
        cmdReady   = !stall;
        reqValid   = 1'($urandom % 2);          // ignored while busy
        reqAddr    = $urandom;
        reqKind    = 2'($urandom);
        reqCountM1 = 4'($urandom);
        reqWrite   = 1'($urandom);
        @(negedge clk);
      end while (stall);
    end
    cmdReady = 1'b0; reqValid = 1'b0;
    chk("R9 done pulse after last handshake", {done, cmdValid, reqReady}, 3'b101);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; cmdReady = 1'b0; reqAddr = '0;
    reqKind = '0; reqCountM1 = '0; reqWrite = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {reqReady, cmdValid, done, alignFault}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 state after reset", {reqReady, cmdValid, done, alignFault}, 4'b1000);

    // R2 byte lanes, write and read
    for (int b = 0; b < 4; b++) runReq(32'h40 + 32'(b), 2'd0, 4'd0, 1'b1, 0);
    runReq(32'h43, 2'd0, 4'd0, 1'b0, 0);
    // R3 halfwords, R4 odd halfword
    runReq(32'h80, 2'd1, 4'd0, 1'b1, 0);
    runReq(32'h82, 2'd1, 4'd0, 1'b1, 50);
    runReq(32'h81, 2'd1, 4'd0, 1'b1, 0);
    runReq(32'h87, 2'd1, 4'd0, 1'b0, 0);
    // R5 word, R4 misaligned word
    runReq(32'h104, 2'd2, 4'd0, 1'b1, 0);
    runReq(32'h102, 2'd2, 4'd0, 1'b1, 0);
    // R6 five-word multiples at offsets 0 and 4
    runReq(32'h200, 2'd3, 4'd4, 1'b0, 0);
    runReq(32'h200, 2'd3, 4'd4, 1'b1, 40);
    runReq(32'h204, 2'd3, 4'd4, 1'b1, 0);
    runReq(32'h204, 2'd3, 4'd4, 1'b0, 40);
    // R6 single-word multiples, 16 words, misaligned multiple
    runReq(32'h300, 2'd3, 4'd0, 1'b1, 0);
    runReq(32'h304, 2'd3, 4'd0, 1'b1, 0);
    runReq(32'h30C, 2'd3, 4'd15, 1'b1, 30);
    runReq(32'h301, 2'd3, 4'd3, 1'b0, 0);
    runReq(32'hFFFF_FFF8, 2'd3, 4'd1, 1'b1, 0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = $urandom;
      if (($urandom % 3) != 0) a[1:0] = 2'b00;
      runReq(a, 2'($urandom), 4'($urandom), 1'($urandom), 30);
    end

    @(negedge clk);
    chk("R9 done drops", done, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule